// File: doc/BRIEF.md
# Multi-Format Audio Serial Formatter

This block turns a pair of parallel 20-bit audio samples into a three-wire serial stream. The three wires are a bit clock, a word clock and a data line. The bit clock is divided down from the system clock. Each frame is 64 bit-clock periods long and is split into two half-frames of 32 slots each. The word clock is high during the left half-frame and low during the right half-frame.

A 2-bit selector picks one of four layouts of the sample inside its half-frame:

- a 16-bit right-justified word, sent MSB first;
- a 20-bit right-justified word, sent LSB first;
- a 20-bit right-justified word, sent MSB first;
- a 20-bit left-justified word, sent MSB first.

Both samples and the selector are captured once per frame, at the frame boundary. Upstream logic can therefore change them at any time during a frame. The new values are used from the start of the next frame.

The word clock and the data line change only on the falling edge of the bit clock. A receiver can sample on the rising edge.

Top module: `afmt_serializer`

## Requirements
- R1: While reset is asserted, and after it is released, bclk is low, lrclk is high and sdata is low. The first frame after reset sends only zeros, because the captured samples reset to zero.
- R2: bclk has a period of 2*HALF_DIV system clocks. It is low in the first half of each period and high in the second half. One period is one slot, and lrclk and sdata change only in the cycle in which bclk falls.
- R3: With fmt_sel = 2'b00, sample bits 19 down to 4 appear in half-frame slots 16 through 31, most significant bit first.
- R4: With fmt_sel = 2'b01, sample bits 0 up to 19 appear in half-frame slots 12 through 31, least significant bit first.
- R5: With fmt_sel = 2'b10, sample bits 19 down to 0 appear in half-frame slots 12 through 31, most significant bit first.
- R6: With fmt_sel = 2'b11, sample bits 19 down to 0 appear in half-frame slots 0 through 19, most significant bit first.
- R7: Every slot that the active format does not fill with data drives sdata low.
- R8: left_in, right_in and fmt_sel are captured only when the last slot of a frame ends. Values applied and then replaced within a frame never appear on sdata. The values present at the boundary govern the whole of the following frame.
- R9: Slots 0 to 31 of a frame carry the left sample with lrclk high. Slots 32 to 63 carry the right sample with lrclk low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| left_in | input | 20 | Left-channel sample |
| right_in | input | 20 | Right-channel sample |
| fmt_sel | input | 2 | Output layout selector (see R3 to R6) |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Word clock, high for left |
| sdata | output | 1 | Serial audio data |

## Verification
The bench sweeps all four layouts. It uses single-bit, all-ones, alternating and random samples, so that a reversed bit order or a slot offset shows up as a wrong bit at a known slot. A design that dropped the wrong four bits in 16-bit mode, or that started a right-justified word one slot early, would corrupt the first or last data slot of every half-frame. Each frame, the bench changes every input twice: once early and once late. A formatter that captured its inputs continuously, or at the wrong boundary, would send a mixture of the two values, or the early one. The first frame after reset must be silent, and swapped channels would show as a data mismatch against lrclk.

// File: rtl/afmt_pkg.sv
package afmt_pkg;

    localparam int SAMPLE_W    = 20;
    localparam int SHORT_W     = 16;
    localparam int HALF_SLOTS  = 32;
    localparam int FRAME_SLOTS = 2 * HALF_SLOTS;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);
    localparam int HSLOT_W     = $clog2(HALF_SLOTS);
    localparam int IDX_W       = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        FMT_RJ16_MSB = 2'b00,
        FMT_RJ20_LSB = 2'b01,
        FMT_RJ20_MSB = 2'b10,
        FMT_LJ20_MSB = 2'b11
    } fmt_e;

endpackage

// File: rtl/afmt_timing.sv
module afmt_timing
    import afmt_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              bclk,
    output logic [SLOT_W-1:0] slot,
    output logic              frame_wrap
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int DIV_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SLOT_W-1:0] slot;
    } tim_t;

    tim_t tim_d, tim_q;
    logic slot_end;

    always_comb begin
        tim_d    = tim_q;
        slot_end = (tim_q.div == DIV_W'(PERIOD - 1));
        if (slot_end) begin
            tim_d.div  = '0;
            tim_d.slot = tim_q.slot + 1'b1;
        end else begin
            tim_d.div = tim_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tim_q <= '0;
        else        tim_q <= tim_d;
    end

    assign bclk       = (tim_q.div >= DIV_W'(HALF_DIV));
    assign slot       = tim_q.slot;
    assign frame_wrap = slot_end && (tim_q.slot == '1);

endmodule

// File: rtl/afmt_latch.sv
module afmt_latch
    import afmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  fmt_e                fmt_in,
    output logic [SAMPLE_W-1:0] left_q,
    output logic [SAMPLE_W-1:0] right_q,
    output fmt_e                fmt_q
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        fmt_e                fmt;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.left  = left_in;
            hold_d.right = right_in;
            hold_d.fmt   = fmt_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q.left  <= '0;
            hold_q.right <= '0;
            hold_q.fmt   <= FMT_RJ16_MSB;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign left_q  = hold_q.left;
    assign right_q = hold_q.right;
    assign fmt_q   = hold_q.fmt;

endmodule

// File: rtl/afmt_slot_map.sv
module afmt_slot_map
    import afmt_pkg::*;
(
    input  fmt_e               fmt,
    input  logic [HSLOT_W-1:0] hslot,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);
    localparam int LONG_START  = HALF_SLOTS - SAMPLE_W;
    localparam int SHORT_START = HALF_SLOTS - SHORT_W;
    localparam int SHORT_DROP  = SAMPLE_W - SHORT_W;

    int s;
    int b;

    always_comb begin
        s     = int'(hslot);
        b     = 0;
        valid = 1'b0;
        unique case (fmt)
            FMT_RJ16_MSB: if (s >= SHORT_START) begin
                valid = 1'b1;
                b     = HALF_SLOTS - 1 - s + SHORT_DROP;
            end
            FMT_RJ20_LSB: if (s >= LONG_START) begin
                valid = 1'b1;
                b     = s - LONG_START;
            end
            FMT_RJ20_MSB: if (s >= LONG_START) begin
                valid = 1'b1;
                b     = HALF_SLOTS - 1 - s;
            end
            FMT_LJ20_MSB: if (s < SAMPLE_W) begin
                valid = 1'b1;
                b     = SAMPLE_W - 1 - s;
            end
            default: valid = 1'b0;
        endcase
        idx = IDX_W'(b);
    end

endmodule

// File: rtl/afmt_serializer.sv
module afmt_serializer
    import afmt_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [19:0] left_in,
    input  logic [19:0] right_in,
    input  logic [1:0]  fmt_sel,
    output logic        bclk,
    output logic        lrclk,
    output logic        sdata
);
    logic [SLOT_W-1:0]   slot;
    logic                frame_wrap;
    logic [SAMPLE_W-1:0] left_q;
    logic [SAMPLE_W-1:0] right_q;
    fmt_e                fmt_q;
    logic [HSLOT_W-1:0]  hslot;
    logic                half;
    logic                bit_valid;
    logic [IDX_W-1:0]    bit_idx;
    logic [SAMPLE_W-1:0] cur_sample;

    afmt_timing #(.HALF_DIV(HALF_DIV)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .slot       (slot),
        .frame_wrap (frame_wrap)
    );

    afmt_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_wrap),
        .left_in  (left_in),
        .right_in (right_in),
        .fmt_in   (fmt_e'(fmt_sel)),
        .left_q   (left_q),
        .right_q  (right_q),
        .fmt_q    (fmt_q)
    );

    assign half  = slot[SLOT_W-1];
    assign hslot = slot[HSLOT_W-1:0];

    afmt_slot_map u_map (
        .fmt   (fmt_q),
        .hslot (hslot),
        .valid (bit_valid),
        .idx   (bit_idx)
    );

    assign cur_sample = half ? right_q : left_q;
    assign lrclk      = ~half;
    assign sdata      = bit_valid & cur_sample[bit_idx];

endmodule

// File: rtl/afmt_checker.sv
module afmt_checker
    import afmt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bclk,
    input logic               lrclk,
    input logic               sdata,
    input logic               frame_wrap,
    input fmt_e               fmt_q,
    input logic [HSLOT_W-1:0] hslot
);
    p_lr_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk) |-> $fell(bclk));

    p_sdata_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $fell(bclk));

    p_fmt_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fmt_q) |-> $past(frame_wrap));

    p_lj_tail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q == FMT_LJ20_MSB && int'(hslot) >= SAMPLE_W) |-> !sdata);

    p_rj16_head_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q == FMT_RJ16_MSB && int'(hslot) < HALF_SLOTS - SHORT_W) |-> !sdata);

endmodule

bind afmt_serializer afmt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk       (bclk),
    .lrclk      (lrclk),
    .sdata      (sdata),
    .frame_wrap (frame_wrap),
    .fmt_q      (fmt_q),
    .hslot      (hslot)
);

// File: tb/tb_afmt_serializer.sv
module tb_afmt_serializer;
    localparam int HD       = 2;
    localparam int SLOT_CLK = 2 * HD;
    localparam int FRAME    = 64 * SLOT_CLK;
    localparam int NFRAMES  = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] left_in = '0;
    logic [19:0] right_in = '0;
    logic [1:0]  fmt_sel = '0;
    logic        bclk, lrclk, sdata;

    afmt_serializer #(.HALF_DIV(HD)) dut (
        .clk(clk), .rst_n(rst_n), .left_in(left_in), .right_in(right_in),
        .fmt_sel(fmt_sel), .bclk(bclk), .lrclk(lrclk), .sdata(sdata)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int k = 0;
    logic [19:0] hl = '0, hr = '0;
    logic [1:0]  hf = '0;
    bit latched = 0;
    bit done = 0;

    // reference timeline: count edges, capture inputs at each frame boundary
    always @(posedge clk) begin
        if (rst_n) begin
            k++;
            if (k % FRAME == 0) begin
                hl = left_in;
                hr = right_in;
                hf = fmt_sel;
                latched = 1;
            end
        end
    end

    function automatic logic exp_bit(logic [1:0] f, logic [19:0] smp, int s);
        bit q[$];
        case (f)
            2'b00: begin
                repeat (16) q.push_back(1'b0);
                for (int i = 19; i >= 4; i--) q.push_back(smp[i]);
            end
            2'b01: begin
                repeat (12) q.push_back(1'b0);
                for (int i = 0; i < 20; i++) q.push_back(smp[i]);
            end
            2'b10: begin
                repeat (12) q.push_back(1'b0);
                for (int i = 19; i >= 0; i--) q.push_back(smp[i]);
            end
            default: begin
                for (int i = 19; i >= 0; i--) q.push_back(smp[i]);
                repeat (12) q.push_back(1'b0);
            end
        endcase
        return q[s];
    endfunction

    task automatic check(string tag, string what, logic got, logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s at k=%0d: got %b expected %b", tag, what, k, got, exp);
        end
    endtask

    function automatic logic [19:0] pattern(int n);
        case (n % 5)
            0: return 20'hA5C3F;
            1: return 20'h00001;
            2: return 20'h80000;
            3: return 20'hFFFFF;
            default: return 20'($urandom);
        endcase
    endfunction

    initial begin
        repeat (3) begin
            @(negedge clk);
            check("R1", "bclk in reset", bclk, 1'b0);
            check("R1", "lrclk in reset", lrclk, 1'b1);
            check("R1", "sdata in reset", sdata, 1'b0);
        end
        left_in  = 20'h12345;
        right_in = 20'h6789A;
        fmt_sel  = 2'b10;
        rst_n    = 1'b1;
        for (int cyc = 0; cyc < NFRAMES * FRAME; cyc++) begin
            int slot, div, s, fidx, phase;
            logic elr, e;
            logic [19:0] smp;
            string tag;
            @(negedge clk);
            slot = (k / SLOT_CLK) % 64;
            div  = k % SLOT_CLK;
            s    = slot % 32;
            elr  = (slot < 32);
            smp  = elr ? hl : hr;
            e    = exp_bit(hf, smp, s);
            check("R2", "bclk", bclk, (div >= HD));
            check("R9", "lrclk", lrclk, elr);
            if (!latched) tag = "R1";
            else begin
                case (hf)
                    2'b00: tag = (s >= 16) ? "R3 R8 R9" : "R7";
                    2'b01: tag = (s >= 12) ? "R4 R8 R9" : "R7";
                    2'b10: tag = (s >= 12) ? "R5 R8 R9" : "R7";
                    default: tag = (s < 20) ? "R6 R8 R9" : "R7";
                endcase
            end
            check(tag, "sdata", sdata, e);
            // stimulus: an early value that must be ignored, then the real one
            phase = k % FRAME;
            fidx  = k / FRAME;
            if (phase == 40) begin
                left_in  = 20'($urandom);
                right_in = 20'($urandom);
                fmt_sel  = 2'($urandom);
            end else if (phase == 180) begin
                left_in  = pattern(fidx);
                right_in = (fidx % 2 == 0) ? ~pattern(fidx) : pattern(fidx + 3);
                fmt_sel  = (fidx < 6) ? 2'(fidx % 4) : 2'(3 - (fidx % 4));
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule